// File: doc/BRIEF.md
# Code-Word Pointer Indexer for a Compressed Bitmap Trie

This block resolves one stage of a longest-prefix-match search held in a compressed bitmap trie. It covers the 16-bit top stage and the two larger chunk shapes below it. A lookup takes a 16-bit key together with a stage selector. It reads one 16-bit code word and one 16-bit base index from two external synchronous-read memories. The code word's upper ten bits select a row of an internal constant table. That table gives, for each of the 16 bit positions, how many heads come before that position. The base index, the code word's 6-bit offset and that count are added, and the sum addresses a pointer memory. The word read there is the result.

Some code words carry the next-hop index themselves. These are code words whose row field lies beyond the last table row. For them the block skips the table and the pointer read, and returns the decoded index straight away. One lookup is in flight at a time. `busy` shows that a lookup is running. `done` pulses for one cycle when `result` and `is_direct` are valid.

Top module: `cw_ptr_indexer`

## Requirements
- R1: While reset is high and after it is released, `done`, `busy`, `is_direct` and `result` are all zero until a lookup is accepted.
- R2: In top mode (`mode`=0) the code word index is key[15:4], the base index is key[15:6] and the bit number is key[3:0].
- R3: A code word splits into a row field (bits 15:6) and a 6-bit offset (bits 5:0).
- R4: For a row field below 676, `ptr_addr` = base word + offset + table count, taken modulo 2^16. `result` is the pointer memory word at that address, and `is_direct` is 0.
- R5: Table row r describes the r-th mask in ascending numeric order among all complete-tree 16-bit masks other than 0x0000 and 0x0001. A mask is complete-tree if it equals 1, or if both of its halves are complete-tree and non-zero, applied down to single bits, with bit 0 as the lowest address. The count for bit b is the number of set mask bits below b. There are exactly 676 rows.
- R6: A row field of 676 or more gives `result` = ((row−676)<<6) | offset and `is_direct`=1, and `ptr_addr` does not change.
- R7: In dense mode (`mode`=1) the code word index is `chunk_cw_base` + key[7:4], the base index is `chunk_base_idx`, and the bit number is key[3:0].
- R8: In very dense mode (`mode`=2) the base index is `chunk_base_idx` + key[7:6]. The other indices are as in R7.
- R9: With `start` sampled at edge E0, `done` rises after edge E0+2 for a direct result and after edge E0+5 for a pointer result. It stays high for exactly one cycle.
- R10: A `start` seen while `busy` is high is ignored. It produces no extra `done` and does not move `code_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (taken when idle) |
| mode | input | 2 | 0 top, 1 dense chunk, 2 very dense chunk |
| key | input | 16 | Top: address bits 31..16; chunk: key[7:0] is the 8-bit slice |
| chunk_cw_base | input | CODE_AW | First code word of the chunk |
| chunk_base_idx | input | BASE_AW | First base index of the chunk |
| code_addr | output | CODE_AW | Code word memory read address |
| code_data | input | 16 | Code word read one cycle after address |
| base_addr | output | BASE_AW | Base index memory read address |
| base_data | input | 16 | Base index read one cycle after address |
| ptr_addr | output | PTR_AW | Pointer memory read address |
| ptr_data | input | 16 | Pointer read one cycle after address |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| is_direct | output | 1 | Result is a next-hop decoded from the code word |
| result | output | 16 | Pointer word or direct next-hop |

## Verification
The bench targets the table edges: row 0 at bit 0, which must add nothing, and row 675 at bit 15, which must add 15. It pairs the second case with a base near 0xFFFF so that a carry beyond 16 bits would misplace the pointer. It also targets the direct boundary at row field 676 (index 0) and at 1023/63 (index 22271). An off-by-one compare there would fetch a pointer instead of decoding, and a wrong subtraction would shift every direct index. Very dense lookups with different key[7:6] values catch a base index that ignores the slice. A burst of `start` during a lookup catches a design that restarts, or that strobes `done` twice.

// File: rtl/cwpi_pkg.sv
package cwpi_pkg;
  localparam int CW_W    = 16;
  localparam int ROW_W   = 10;
  localparam int OFS_W   = 6;
  localparam int BIT_W   = 4;
  localparam int LANES   = 1 << BIT_W;
  localparam int CNT_W   = 4;
  localparam int SUB4_N  = 5;
  localparam int SUB8_N  = 1 + SUB4_N * SUB4_N;
  localparam int MAP_ROWS = SUB8_N * SUB8_N;
  localparam int ENTRY_W = LANES * CNT_W;

  typedef enum logic [1:0] {
    MODE_TOP   = 2'd0,
    MODE_DENSE = 2'd1,
    MODE_VDENSE = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_MAP, S_PWAIT, S_PRD
  } state_e;

  // complete-tree 4-bit masks, ascending
  function automatic logic [3:0] sub4(input int i);
    int k;
    if (i == 0) return 4'b0001;
    k = i - 1;
    return {(k >= 2) ? 2'b11 : 2'b01, (k % 2 == 1) ? 2'b11 : 2'b01};
  endfunction

  // complete-tree 8-bit masks, ascending
  function automatic logic [7:0] sub8(input int i);
    int k;
    if (i == 0) return 8'h01;
    k = i - 1;
    return {sub4(k / SUB4_N), sub4(k % SUB4_N)};
  endfunction

  function automatic logic [15:0] row_mask(input int r);
    return {sub8(r / SUB8_N), sub8(r % SUB8_N)};
  endfunction

  // per-lane count of set bits strictly below the lane
  function automatic logic [ENTRY_W-1:0] row_entry(input int r);
    logic [15:0]        m;
    logic [ENTRY_W-1:0] e;
    logic [CNT_W-1:0]   c;
    m = row_mask(r);
    e = '0;
    c = '0;
    for (int b = 0; b < LANES; b++) begin
      e[b*CNT_W +: CNT_W] = c;
      if (m[b]) c = c + 1'b1;
    end
    return e;
  endfunction
endpackage

// File: rtl/cwpi_addr_gen.sv
module cwpi_addr_gen #(
  parameter int CODE_AW = 13,
  parameter int BASE_AW = 11
) (
  input  logic [1:0]                 mode,
  input  logic [15:0]                key,
  input  logic [CODE_AW-1:0]         chunk_cw_base,
  input  logic [BASE_AW-1:0]         chunk_base_idx,
  output logic [CODE_AW-1:0]         cw_idx,
  output logic [BASE_AW-1:0]         base_idx,
  output logic [cwpi_pkg::BIT_W-1:0] bit_no
);
  import cwpi_pkg::*;

  always_comb begin
    bit_no = key[3:0];
    unique case (mode)
      MODE_TOP: begin
        cw_idx   = CODE_AW'(key[15:4]);
        base_idx = BASE_AW'(key[15:6]);
      end
      MODE_VDENSE: begin
        cw_idx   = chunk_cw_base + CODE_AW'(key[7:4]);
        base_idx = chunk_base_idx + BASE_AW'(key[7:6]);
      end
      default: begin
        cw_idx   = chunk_cw_base + CODE_AW'(key[7:4]);
        base_idx = chunk_base_idx;
      end
    endcase
  end
endmodule

// File: rtl/cwpi_cw_decode.sv
module cwpi_cw_decode (
  input  logic [cwpi_pkg::CW_W-1:0]  cw,
  output logic [cwpi_pkg::ROW_W-1:0] row,
  output logic [cwpi_pkg::OFS_W-1:0] ofs,
  output logic                       direct,
  output logic [15:0]                nh
);
  import cwpi_pkg::*;

  logic [ROW_W-1:0] hi;

  assign row    = cw[CW_W-1 -: ROW_W];
  assign ofs    = cw[OFS_W-1:0];
  assign direct = row >= ROW_W'(MAP_ROWS);
  assign hi     = row - ROW_W'(MAP_ROWS);
  assign nh     = 16'({hi, ofs});
endmodule

// File: rtl/cwpi_map_rom.sv
module cwpi_map_rom #(
  parameter int ROWS = cwpi_pkg::MAP_ROWS
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [cwpi_pkg::ROW_W-1:0]    row,
  output logic [cwpi_pkg::ENTRY_W-1:0]  entry
);
  import cwpi_pkg::*;

  logic [ENTRY_W-1:0] rom [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) rom[r] = row_entry(r);
  end

  always_ff @(posedge clk) begin
    if (en) entry <= rom[row];
  end
endmodule

// File: rtl/cw_ptr_indexer.sv
module cw_ptr_indexer #(
  parameter int CODE_AW = 13,
  parameter int BASE_AW = 11,
  parameter int PTR_AW  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic [15:0]        key,
  input  logic [CODE_AW-1:0] chunk_cw_base,
  input  logic [BASE_AW-1:0] chunk_base_idx,
  output logic [CODE_AW-1:0] code_addr,
  input  logic [15:0]        code_data,
  output logic [BASE_AW-1:0] base_addr,
  input  logic [15:0]        base_data,
  output logic [PTR_AW-1:0]  ptr_addr,
  input  logic [15:0]        ptr_data,
  output logic               busy,
  output logic               done,
  output logic               is_direct,
  output logic [15:0]        result
);
  import cwpi_pkg::*;

  state_e              state;
  logic [CODE_AW-1:0]  ag_cw;
  logic [BASE_AW-1:0]  ag_base;
  logic [BIT_W-1:0]    ag_bit;
  logic [ROW_W-1:0]    dc_row;
  logic [OFS_W-1:0]    dc_ofs;
  logic                dc_direct;
  logic [15:0]         dc_nh;
  logic [ENTRY_W-1:0]  map_q;
  logic [BIT_W-1:0]    bit_q;
  logic [OFS_W-1:0]    ofs_q;
  logic [15:0]         base_q;
  logic [CNT_W-1:0]    lane_cnt;
  logic [15:0]         pix;
  logic                rom_en;

  cwpi_addr_gen #(.CODE_AW(CODE_AW), .BASE_AW(BASE_AW)) u_ag (
    .mode(mode), .key(key), .chunk_cw_base(chunk_cw_base),
    .chunk_base_idx(chunk_base_idx), .cw_idx(ag_cw),
    .base_idx(ag_base), .bit_no(ag_bit)
  );

  cwpi_cw_decode u_dc (
    .cw(code_data), .row(dc_row), .ofs(dc_ofs),
    .direct(dc_direct), .nh(dc_nh)
  );

  assign rom_en = (state == S_DECODE) && !dc_direct;

  cwpi_map_rom #(.ROWS(MAP_ROWS)) u_rom (
    .clk(clk), .en(rom_en), .row(dc_row), .entry(map_q)
  );

  assign lane_cnt = map_q[bit_q*CNT_W +: CNT_W];
  assign pix      = base_q + 16'(ofs_q) + 16'(lane_cnt);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      code_addr <= '0;
      base_addr <= '0;
      ptr_addr  <= '0;
      result    <= '0;
      is_direct <= 1'b0;
      done      <= 1'b0;
      bit_q     <= '0;
      ofs_q     <= '0;
      base_q    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          code_addr <= ag_cw;
          base_addr <= ag_base;
          bit_q     <= ag_bit;
          state     <= S_FETCH;
        end
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          ofs_q  <= dc_ofs;
          base_q <= base_data;
          if (dc_direct) begin
            result    <= dc_nh;
            is_direct <= 1'b1;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_MAP;
          end
        end
        S_MAP: begin
          ptr_addr <= PTR_AW'(pix);
          state    <= S_PWAIT;
        end
        S_PWAIT: state <= S_PRD;
        S_PRD: begin
          result    <= ptr_data;
          is_direct <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwpi_checker.sv
module cwpi_checker #(
  parameter int CODE_AW = 13,
  parameter int PTR_AW  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [1:0]         mode,
  input logic [15:0]        key,
  input logic [CODE_AW-1:0] code_addr,
  input logic [PTR_AW-1:0]  ptr_addr,
  input logic               busy,
  input logic               done,
  input logic               is_direct
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_top_index_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 2'd0) |=> code_addr == CODE_AW'($past(key[15:4])));

  p_hold_addr_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(code_addr));

  p_direct_no_ptr_r6: assert property (@(posedge clk) disable iff (rst)
    (done && is_direct) |-> $stable(ptr_addr));
endmodule

bind cw_ptr_indexer cwpi_checker #(.CODE_AW(CODE_AW), .PTR_AW(PTR_AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .key(key),
  .code_addr(code_addr), .ptr_addr(ptr_addr), .busy(busy),
  .done(done), .is_direct(is_direct)
);

// File: tb/sim_cw_ptr_indexer.sv
module sim_cw_ptr_indexer;
  localparam int CODE_AW = 13;
  localparam int BASE_AW = 11;
  localparam int PTR_AW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [15:0] key = '0;
  logic [CODE_AW-1:0] ccb = '0;
  logic [BASE_AW-1:0] cbi = '0;
  logic [CODE_AW-1:0] code_addr;
  logic [BASE_AW-1:0] base_addr;
  logic [PTR_AW-1:0]  ptr_addr;
  logic [15:0] code_data = '0, base_data = '0, ptr_data = '0;
  logic busy, done, is_direct;
  logic [15:0] result;

  always #10 clk = ~clk;

  cw_ptr_indexer #(.CODE_AW(CODE_AW), .BASE_AW(BASE_AW), .PTR_AW(PTR_AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .key(key),
    .chunk_cw_base(ccb), .chunk_base_idx(cbi),
    .code_addr(code_addr), .code_data(code_data),
    .base_addr(base_addr), .base_data(base_data),
    .ptr_addr(ptr_addr), .ptr_data(ptr_data),
    .busy(busy), .done(done), .is_direct(is_direct), .result(result)
  );

  // memory models
  logic [15:0] code_ov [int];
  logic [15:0] base_ov [int];

  function automatic logic [15:0] code_val(input int a);
    if (code_ov.exists(a)) return code_ov[a];
    return 16'(a * 40503) ^ 16'h3C1D;
  endfunction
  function automatic logic [15:0] base_val(input int a);
    if (base_ov.exists(a)) return base_ov[a];
    return 16'(a * 2654435 + 77);
  endfunction
  function automatic logic [15:0] ptr_val(input int a);
    return 16'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    code_data <= code_val(int'(code_addr));
    base_data <= base_val(int'(base_addr));
    ptr_data  <= ptr_val(int'(ptr_addr));
  end

  // row table built from the R5 definition by scanning every mask
  logic [15:0] rows [676];
  int n_rows;

  function automatic bit tree_ok(input logic [15:0] m);
    bit v [16];
    for (int j = 0; j < 16; j++) v[j] = m[j];
    for (int s = 2; s <= 16; s = s * 2) begin
      for (int j = 0; j < 16 / s; j++) begin
        logic [15:0] blk;
        blk = (m >> (j * s)) & 16'((32'd1 << s) - 1);
        v[j] = (blk == 16'd1) || (v[2*j] && v[2*j+1]);
      end
    end
    return v[0];
  endfunction

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit q_dir [$];
  logic [15:0] q_val [$];
  int q_cyc [$];
  string q_tag [$];

  task automatic expect_of(input logic [1:0] md, input logic [15:0] k,
                           input logic [CODE_AW-1:0] cb, input logic [BASE_AW-1:0] bb,
                           output bit dir, output logic [15:0] val);
    int ci, bi, b, ten, six, cnt;
    logic [15:0] cw, m, p;
    if (md == 2'd0) begin ci = int'(k[15:4]); bi = int'(k[15:6]); end        // R2
    else if (md == 2'd2) begin ci = int'(CODE_AW'(cb + k[7:4])); bi = int'(BASE_AW'(bb + k[7:6])); end // R8
    else begin ci = int'(CODE_AW'(cb + k[7:4])); bi = int'(bb); end              // R7
    b  = int'(k[3:0]);
    cw = code_val(ci);
    ten = int'(cw[15:6]); six = int'(cw[5:0]);                                   // R3
    if (ten >= 676) begin                                                         // R6
      dir = 1'b1;
      val = 16'(((ten - 676) << 6) | six);
    end else begin                                                                // R4 R5
      m = rows[ten];
      cnt = 0;
      for (int j = 0; j < b; j++) if (m[j]) cnt++;
      p = 16'(int'(base_val(bi)) + six + cnt);
      dir = 1'b0;
      val = ptr_val(int'(p));
    end
  endtask

  task automatic lookup(input logic [1:0] md, input logic [15:0] k,
                        input logic [CODE_AW-1:0] cb, input logic [BASE_AW-1:0] bb,
                        input string tag);
    bit d; logic [15:0] v;
    while (busy) @(negedge clk);
    expect_of(md, k, cb, bb, d, v);
    q_dir.push_back(d); q_val.push_back(v);
    q_cyc.push_back(cyc + 1 + (d ? 2 : 5));                                       // R9
    q_tag.push_back(tag);
    mode = md; key = k; ccb = cb; cbi = bb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      checks++;
      if (q_dir.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected done, result=%h expected no done", result);
      end else begin
        bit d; logic [15:0] v; int c; string t;
        d = q_dir.pop_front(); v = q_val.pop_front();
        c = q_cyc.pop_front(); t = q_tag.pop_front();
        if (is_direct !== d || result !== v || cyc != c) begin
          errors++;
          $display("FAIL %s R9: dir=%0b res=%h cyc=%0d expected dir=%0b res=%h cyc=%0d",
                   t, is_direct, result, cyc, d, v, c);
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [PTR_AW-1:0] pa;
    n_rows = 0;
    for (int m = 2; m < 65536; m++)
      if (tree_ok(16'(m)) && n_rows < 676) begin rows[n_rows] = 16'(m); n_rows++; end
      else if (tree_ok(16'(m))) n_rows++;
    check(n_rows == 676, $sformatf("R5 row count actual %0d expected 676", n_rows));

    // directed memory contents
    code_ov[32'hABC] = {10'd5, 6'd9};     base_ov[32'h2AF] = 16'd100;
    code_ov[32'h123] = {10'd0, 6'd0};     base_ov[32'h048] = 16'd7;
    code_ov[32'h456] = {10'd675, 6'd63};  base_ov[32'h115] = 16'hFFF0;
    code_ov[32'h777] = {10'd676, 6'd0};
    code_ov[32'h888] = {10'd1023, 6'd63};
    code_ov[32'h100C] = {10'd40, 6'd2};   base_ov[32'h400] = 16'd500;
    code_ov[32'h1004] = {10'd300, 6'd1};  base_ov[32'h401] = 16'd900;
    base_ov[32'h403] = 16'd1200;

    repeat (3) @(negedge clk);
    check(done == 0 && busy == 0 && is_direct == 0 && result == 0,
          $sformatf("R1 in reset: done=%0b busy=%0b dir=%0b res=%h expected 0", done, busy, is_direct, result));
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && busy == 0 && is_direct == 0 && result == 0,
          $sformatf("R1 after reset: done=%0b busy=%0b dir=%0b res=%h expected 0", done, busy, is_direct, result));

    lookup(2'd0, 16'hABCD, '0, '0, "R2 R3 R4 row5");
    lookup(2'd0, 16'h1230, '0, '0, "R5 row0 bit0");
    lookup(2'd0, 16'h456F, '0, '0, "R4 R5 row675 bit15 wrap");
    while (busy) @(negedge clk);
    pa = ptr_addr;
    lookup(2'd0, 16'h7770, '0, '0, "R6 row676");
    while (busy) @(negedge clk);
    check(ptr_addr == pa, $sformatf("R6 ptr_addr actual %h expected %h", ptr_addr, pa));
    lookup(2'd0, 16'h8880, '0, '0, "R6 row1023");
    lookup(2'd1, 16'h00C5, 13'h1000, 11'h400, "R7 dense");
    lookup(2'd2, 16'h00C5, 13'h1000, 11'h400, "R8 vdense hi");
    lookup(2'd2, 16'h0045, 13'h1000, 11'h400, "R8 vdense lo");

    // R10: start held during a lookup
    lookup(2'd0, 16'hABCD, '0, '0, "R10 first");
    start = 1'b1; key = 16'h1230;
    @(negedge clk); @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (8) @(negedge clk);
    check(q_dir.size() == 0 && !busy,
          $sformatf("R10 pending=%0d busy=%0b expected 0 0", q_dir.size(), busy));

    lf = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      lf = lf * 32'd1664525 + 32'd1013904223;
      lookup(2'(int'(lf[1:0]) % 3), lf[31:16], 13'(lf[15:3]), 11'(lf[13:3]), "R4 R6 R7 R8 sweep");
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_dir.size() == 0, $sformatf("R9 missing done actual %0d pending expected 0", q_dir.size()));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule